// File: doc/BRIEF.md
# Priority Round-Robin Burst Arbiter

This block decides which of several requesting masters may use one shared slave port. Every master carries a three-bit priority level, where a smaller number means more urgent. Among the masters requesting at a decision point, the arbiter keeps those at the most urgent level present and picks one of them in rotation. The rotation position is remembered separately for each of the eight levels.

A grant covers a whole burst. When a master wins, the arbiter latches that master's burst length, written as the number of beats minus one. It then counts the beats that the slave reports. The grant ends on the final counted beat, or earlier on a beat that the slave marks as last. The next decision is made in that same cycle, so a new owner can follow without an idle cycle.

Priority levels reload to per-master defaults on reset and can be rewritten through a small configuration port. A write made during a burst leaves the current owner in place and takes effect at the next decision.

Top module: `prio_rr_arbiter`

## Requirements
- R1: After reset no grant is asserted and `gnt_idx` is 0. Levels return to the defaults 2,2,0,0,2,5 for masters 0..5, with 0 the most urgent and 7 the least.
- R2: `gnt` is all-zero or one-hot. When a bit is set, `gnt_idx` holds that bit's position; when no bit is set, `gnt_idx` is 0.
- R3: At a decision point the winner is a requesting master whose level is numerically lowest among all requesting masters.
- R4: Among requesters at the winning level, the winner is the first one found going upward (wrapping) from the master last granted at that level. Before any grant at a level, the search starts at master 0.
- R5: A grant at one level leaves the rotation position of every other level unchanged.
- R6: A granted master holds the grant for burst-length+1 slave beats. The burst-length field is beats minus one, and 0 means a single access. Cycles without a beat extend the hold.
- R7: A beat with `last_beat` high ends the burst at once, even if the counted length has not been reached.
- R8: A decision is made both in any cycle with no active grant and in the cycle of a burst's final beat. The resulting grant appears one clock later.
- R9: A level written through the configuration port (`cfg_we`, `cfg_idx`, `cfg_lvl`) does not move a grant in progress. It decides the next decision point. A write to an index of NUM_MST or above has no effect.
- R10: A decision point with no requests leaves `gnt` at zero from the next clock and keeps every rotation position.
- R11: `beat` and `last_beat` have no effect while no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NUM_MST | Request, one bit per master |
| burst_len | input | NUM_MST*LEN_W | Per-master burst length field, beats minus one |
| beat | input | 1 | Slave completed one beat of the current burst |
| last_beat | input | 1 | Qualifies `beat`: this beat closes the burst |
| cfg_we | input | 1 | Priority level write strobe |
| cfg_idx | input | IDX_W | Master whose level is written |
| cfg_lvl | input | 3 | New level, 0 most urgent |
| gnt | output | NUM_MST | One-hot grant |
| gnt_idx | output | IDX_W | Index of the granted master |

## Verification
Grant outputs come from flops, so a decision made from the inputs present before a rising edge shows up on `gnt` and `gnt_idx` right after that edge. A burst's final beat and the next owner's grant therefore fall on the same edge. The reference model advances once per rising edge from the input values held across it. The outputs are compared at the following falling edge, and new stimulus is applied only after that comparison. Configuration writes are applied in the model after the decision of the same edge, because the design decides from the stored levels.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;

  // Position reached by stepping forward from `last` by `step`, wrapping at n.
  function automatic int rr_slot(input int last, input int step, input int n);
    return (last + step) % n;
  endfunction

  // True when a beat closes the burst: count reached or slave marked it last.
  function automatic logic burst_closes(input logic act, input logic bt,
                                        input logic lst, input logic cnt_hit);
    return act && bt && (cnt_hit || lst);
  endfunction
endpackage

// File: rtl/prio_regs.sv
module prio_regs import arb_pkg::*; #(
  parameter int NUM_MST = 6,
  parameter int IDX_W   = 3,
  parameter logic [NUM_MST*LVL_W-1:0] DEF_PRIO = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  lvl_t                     cfg_lvl,
  output logic [NUM_MST*LVL_W-1:0] lvl_flat
);
  for (genvar m = 0; m < NUM_MST; m++) begin : g_lvl
    lvl_t lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= DEF_PRIO[m*LVL_W +: LVL_W];
      else if (cfg_we && (cfg_idx == IDX_W'(m))) lvl_q <= cfg_lvl;
    end
    assign lvl_flat[m*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/level_select.sv
module level_select import arb_pkg::*; #(
  parameter int NUM_MST = 6
) (
  input  logic [NUM_MST-1:0]       req,
  input  logic [NUM_MST*LVL_W-1:0] lvl_flat,
  output logic                     any_req,
  output lvl_t                     best_lvl,
  output logic [NUM_MST-1:0]       cand
);
  always_comb begin
    best_lvl = '1;
    any_req  = |req;
    for (int m = 0; m < NUM_MST; m++) begin
      if (req[m] && (lvl_flat[m*LVL_W +: LVL_W] < best_lvl))
        best_lvl = lvl_flat[m*LVL_W +: LVL_W];
    end
    for (int m = 0; m < NUM_MST; m++)
      cand[m] = req[m] && (lvl_flat[m*LVL_W +: LVL_W] == best_lvl);
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick import arb_pkg::*; #(
  parameter int NUM_MST = 6,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MST-1:0] cand,
  input  lvl_t               best_lvl,
  input  logic               take,
  output logic [IDX_W-1:0]   pick_idx
);
  logic [IDX_W-1:0] ptr_q [NUM_LVL];
  logic             found;
  int               slot;

  always_comb begin
    pick_idx = '0;
    found    = 1'b0;
    slot     = 0;
    for (int s = 1; s <= NUM_MST; s++) begin
      slot = rr_slot(int'(ptr_q[best_lvl]), s, NUM_MST);
      if (!found && cand[slot]) begin
        found    = 1'b1;
        pick_idx = IDX_W'(slot);
      end
    end
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[l] <= IDX_W'(NUM_MST - 1);
      else if (take && (best_lvl == lvl_t'(l))) ptr_q[l] <= pick_idx;
    end

    // R5: only the winning level's rotation position may move
    assert_ptr_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!take || (best_lvl != lvl_t'(l))) |=> $stable(ptr_q[l]));
  end

  // R4: the chosen master is one of the candidates at the winning level
  assert_pick_is_cand_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> cand[pick_idx]);
endmodule

// File: rtl/burst_tracker.sv
module burst_tracker import arb_pkg::*; #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic             beat,
  input  logic             last_beat,
  output logic             busy,
  output logic             burst_end
);
  logic [LEN_W-1:0] cnt_q, len_q;

  assign burst_end = burst_closes(busy, beat, last_beat, cnt_q == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      len_q <= start_len;
    end else if (burst_end) begin
      busy  <= 1'b0;
    end else if (busy && beat) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: the beat count never passes the latched length
  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= len_q));

  // R11: beats without an active burst cannot start one
  assert_idle_beats_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter import arb_pkg::*; #(
  parameter int NUM_MST = 6,
  parameter int LEN_W   = 4,
  parameter int IDX_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1,
  parameter logic [NUM_MST*LVL_W-1:0] DEF_PRIO =
    {3'd5, 3'd2, 3'd0, 3'd0, 3'd2, 3'd2}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_MST-1:0]       req,
  input  logic [NUM_MST*LEN_W-1:0] burst_len,
  input  logic                     beat,
  input  logic                     last_beat,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [LVL_W-1:0]         cfg_lvl,
  output logic [NUM_MST-1:0]       gnt,
  output logic [IDX_W-1:0]         gnt_idx
);
  logic [NUM_MST*LVL_W-1:0] lvl_flat;
  logic                     any_req;
  lvl_t                     best_lvl;
  logic [NUM_MST-1:0]       cand;
  logic [IDX_W-1:0]         pick_idx;
  logic                     busy, burst_end;
  logic                     arb_point, start;
  logic [LEN_W-1:0]         start_len;
  logic [IDX_W-1:0]         owner_q;

  assign arb_point = !busy || burst_end;
  assign start     = arb_point && any_req;
  assign start_len = burst_len[pick_idx*LEN_W +: LEN_W];

  prio_regs #(.NUM_MST(NUM_MST), .IDX_W(IDX_W), .DEF_PRIO(DEF_PRIO)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_lvl(cfg_lvl), .lvl_flat(lvl_flat));

  level_select #(.NUM_MST(NUM_MST)) u_lvl (
    .req(req), .lvl_flat(lvl_flat), .any_req(any_req),
    .best_lvl(best_lvl), .cand(cand));

  rr_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .cand(cand), .best_lvl(best_lvl),
    .take(start), .pick_idx(pick_idx));

  burst_tracker #(.LEN_W(LEN_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
    .beat(beat), .last_beat(last_beat), .busy(busy), .burst_end(burst_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     owner_q <= '0;
    else if (start) owner_q <= pick_idx;
  end

  always_comb begin
    for (int m = 0; m < NUM_MST; m++)
      gnt[m] = busy && (owner_q == IDX_W'(m));
    gnt_idx = busy ? owner_q : '0;
  end

  // R2: at most one master granted
  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R3: the winner sits at the most urgent requesting level
  assert_pick_from_best_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> cand[pick_idx]);

  // R6: mid-burst the grant does not move
  assert_hold_mid_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !burst_end) |=> ($stable(gnt) && (gnt != '0)));

  // R8: a closing beat with requests pending hands over on the next clock
  assert_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && any_req) |=> (gnt != '0));

  // R10: a decision point without requests leaves no grant
  assert_idle_no_gnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_point && !any_req) |=> (gnt == '0));
endmodule

// File: tb/tb_prio_rr_arbiter.sv
module tb_prio_rr_arbiter;
  localparam int N  = 6;
  localparam int LW = 4;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N*LW-1:0] blen = '0;
  logic          beat = 1'b0, last = 1'b0, cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [2:0]    cfg_lvl = '0;
  logic [N-1:0]  gnt;
  logic [IW-1:0] gnt_idx;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  // reference model state
  int m_prio[N];
  int m_ptr[8];
  bit m_busy;
  int m_owner, m_cnt, m_len;

  always #5 clk = ~clk;

  prio_rr_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req(req), .burst_len(blen), .beat(beat),
    .last_beat(last), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl),
    .gnt(gnt), .gnt_idx(gnt_idx));

  task automatic model_reset();
    int defs[N] = '{2, 2, 0, 0, 2, 5};
    for (int i = 0; i < N; i++) m_prio[i] = defs[i];
    for (int l = 0; l < 8; l++) m_ptr[l] = N - 1;
    m_busy = 0; m_owner = 0; m_cnt = 0; m_len = 0;
  endtask

  task automatic model_tick();
    bit ended;
    int best;
    bit got;
    int s;
    ended = m_busy && beat && ((m_cnt == m_len) || last);
    if (!m_busy || ended) begin
      best = 8;
      for (int i = 0; i < N; i++) if (req[i] && m_prio[i] < best) best = m_prio[i];
      if (best < 8) begin
        got = 0;
        for (int k = 1; k <= N; k++) begin
          s = (m_ptr[best] + k) % N;
          if (!got && req[s] && m_prio[s] == best) begin
            got = 1; m_owner = s; m_ptr[best] = s;
          end
        end
        m_busy = 1; m_cnt = 0; m_len = int'(blen[m_owner*LW +: LW]);
      end else begin
        m_busy = 0;
      end
    end else if (m_busy && beat) begin
      m_cnt++;
    end
    if (cfg_we && int'(cfg_idx) < N) m_prio[cfg_idx] = int'(cfg_lvl);
  endtask

  task automatic compare();
    logic [N-1:0]  eg;
    logic [IW-1:0] ei;
    eg = m_busy ? (N'(1) << m_owner) : '0;
    ei = m_busy ? IW'(m_owner) : '0;
    checks++;
    if (gnt !== eg || gnt_idx !== ei) begin
      errors++;
      $display("FAIL %s model: gnt=%b idx=%0d expected gnt=%b idx=%0d", phase, gnt, gnt_idx, eg, ei);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare();
  endtask

  // directed check; who = -1 means no grant
  task automatic expect_owner(string tag, int who);
    logic [N-1:0] eg;
    eg = (who < 0) ? '0 : (N'(1) << who);
    checks++;
    if (gnt !== eg || gnt_idx !== ((who < 0) ? IW'(0) : IW'(who))) begin
      errors++;
      $display("FAIL %s directed: gnt=%b idx=%0d expected master %0d", tag, gnt, gnt_idx, who);
    end
  endtask

  task automatic set_len(int m, int v);
    blen[m*LW +: LW] = LW'(v);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    expect_owner("R1", -1);
    rst_n = 1'b1;
    phase = "R1"; step(); expect_owner("R1", -1);

    // R3 / R4 / R8: singles back to back, level 0 masters 2 and 3 rotate
    phase = "R3"; req = 6'b111111; beat = 1'b1;
    step(); expect_owner("R3", 2);
    phase = "R4"; step(); expect_owner("R8", 3);
    step(); expect_owner("R4", 2);
    phase = "R3"; req = 6'b110011;
    step(); expect_owner("R3", 0);
    phase = "R4"; step(); expect_owner("R4", 1);
    step(); expect_owner("R4", 4);
    step(); expect_owner("R4", 0);
    // R5: level 0 resumes after master 2, level 2 after master 0
    phase = "R5"; req = 6'b001100;
    step(); expect_owner("R5", 3);
    req = 6'b010011;
    step(); expect_owner("R5", 1);
    // R10 / R11: idle, beats ignored, pointers kept
    phase = "R10"; req = '0;
    step(); expect_owner("R10", -1);
    phase = "R11"; last = 1'b1;
    step(); expect_owner("R11", -1);
    last = 1'b0;
    phase = "R10"; req = 6'b010011;
    step(); expect_owner("R10", 4);
    req = '0; step(); expect_owner("R10", -1);

    // R6: four-beat burst with gaps
    phase = "R6"; beat = 1'b0; set_len(0, 3); req = 6'b000011;
    step(); expect_owner("R6", 0);
    foreach (blen[i]) ; // no-op keeps style simple
    begin
      bit pat[5] = '{1, 0, 1, 0, 1};
      for (int k = 0; k < 5; k++) begin
        beat = pat[k]; step(); expect_owner("R6", 0);
      end
    end
    beat = 1'b1; step(); expect_owner("R6", 1);

    // R7: early close through last_beat
    phase = "R7"; req = '0; step(); expect_owner("R7", -1);
    set_len(0, 7); req = 6'b000001; beat = 1'b0;
    step(); expect_owner("R7", 0);
    beat = 1'b1; step(); step(); expect_owner("R7", 0);
    last = 1'b1; req = '0; step(); expect_owner("R7", -1);
    last = 1'b0;

    // R9: level write mid-burst waits for the boundary
    phase = "R9"; set_len(0, 3); set_len(5, 0); req = 6'b000001; beat = 1'b0;
    step(); expect_owner("R9", 0);
    req = 6'b100001; cfg_we = 1'b1; cfg_idx = 3'd5; cfg_lvl = 3'd0;
    step(); expect_owner("R9", 0);
    cfg_we = 1'b0; beat = 1'b1;
    for (int k = 0; k < 3; k++) begin step(); expect_owner("R9", 0); end
    step(); expect_owner("R9", 5);
    // out-of-range index has no effect: master 5 stays at level 0
    cfg_we = 1'b1; cfg_idx = 3'd7; cfg_lvl = 3'd7; req = 6'b100100;
    step(); cfg_we = 1'b0;
    expect_owner("R9", 2);
    step(); expect_owner("R9", 5);

    // R2: mixed random traffic against the model
    phase = "R2";
    for (int c = 0; c < 3000; c++) begin
      req  = N'($urandom);
      beat = ($urandom % 4) != 0;
      last = ($urandom % 8) == 0;
      for (int m = 0; m < N; m++) set_len(m, $urandom % 5);
      cfg_we  = ($urandom % 16) == 0;
      cfg_idx = IW'($urandom);
      cfg_lvl = 3'($urandom);
      step();
    end
    req = '0; cfg_we = 1'b0;
    step(); step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule